// File: doc/BRIEF.md
# Multi-Channel Pulse-Width DAC Bank

This block drives fourteen pulse-width-modulated outputs for analog trim voltages. Each channel holds an 8-bit duty code. A host writes and reads these codes over a small synchronous register bus. One free-running period counter, clocked by the crystal clock, is shared by all channels. Each channel compares that count against its code. Every output models an open-drain pin: the block either asserts a pull-low enable or releases the pin. An external filter turns the duty cycle into a DC level.

A mode input sets the period length. When it is 0 the period is 256 clocks. When it is 1 the period is 253 clocks, and the three highest codes then hold the pin released for the whole period. In the 256-clock mode the pin is pulled low for at least one clock per period, even at the highest code. Code 00h keeps the pin pulled low in both modes.

Each channel has a staged code and an active shadow code. A write updates only the staged code. The shadow takes the staged value at the next period boundary, so a write never cuts a pulse short.

The period sequencer has two states:
- `SEQ_COUNT`: the counter advances by one each clock.
- `SEQ_LAST`: the counter holds the final count of the period.

It makes three transitions:
- `SEQ_COUNT` to `SEQ_LAST`, when the next count equals the final count.
- `SEQ_LAST` to `SEQ_COUNT`, when the counter wraps to 0 and every shadow reloads.
- Either state to `SEQ_COUNT`, when the mode input changes. This restarts the counter at 0 and also reloads every shadow.

Top module: `pwm_dac_bank`

## Requirements
- R1: Channel n (n = 0..13) holds its code at register address n. A read of address n returns the last code written there.
- R2: The period counter runs 0..255 when `short_period`=0 and 0..252 when `short_period`=1. The time between consecutive release edges of a channel therefore equals 256 or 253 clocks.
- R3: For a code c smaller than the period length, a channel is released (`dac_pull_low` bit = 0) for exactly c clocks of each period and pulled low for the rest. The released clocks come first, starting at count 0.
- R4: With `short_period`=1, codes FDh, FEh and FFh keep the pin released on every clock.
- R5: Code 00h keeps the pin pulled low on every clock in both modes.
- R6: With `short_period`=0, code FFh gives 255 released clocks and 1 pulled-low clock per period.
- R7: A code written during a period does not change that period's output. The new code takes effect from the next period.
- R8: After reset, every channel's code reads 80h and every channel is released for 128 of each 256 clocks.
- R9: A change of `short_period` restarts the counter at 0 and reloads all codes. The output of a channel with a nonzero code is released on the second clock after the change is sampled.
- R10: Each channel's duty depends only on its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| short_period | input | 1 | 1 = 253-clock period, 0 = 256-clock period |
| reg_we | input | 1 | Write strobe for the code register |
| reg_addr | input | 4 | Channel select |
| reg_wdata | input | 8 | Code to write |
| reg_rdata | output | 8 | Staged code of the selected channel (combinational) |
| dac_pull_low | output | 14 | Per-channel open-drain pull-low enable; 0 releases the pin |

## Verification
Readback is combinational, so the bench samples `reg_rdata` on the falling edge in the same cycle as the address. Outputs are registered one clock behind the counter, and a new code waits for the next period boundary. Duty checks therefore wait two full periods after any write or mode change, then count released clocks over exactly one period length; the count does not depend on where the window starts. The deferred-write and restart checks lock to an observed release edge, which marks count 0 plus one clock. Against that edge, the bench expects the old duty for the current period and the new duty for the next. After a mode change it expects the pin still low one clock later and released two clocks later.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Period sequencer states
    typedef enum logic [0:0] {
        SEQ_COUNT = 1'b0,   // counter advancing within a period
        SEQ_LAST  = 1'b1    // counter sits on the final count
    } seq_state_t;

    // Last count of a period for a given code width and trim
    function automatic int unsigned period_last(input int unsigned code_w,
                                                input int unsigned trim);
        return (32'd1 << code_w) - 32'd1 - trim;
    endfunction

endpackage

// File: rtl/pwm_code_regs.sv
module pwm_code_regs #(
    parameter int NUM_CH     = 14,
    parameter int CODE_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int RESET_CODE = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CODE_W-1:0]          wdata,
    output logic [CODE_W-1:0]          rdata,
    output logic [NUM_CH*CODE_W-1:0]   staged_flat
);

    logic [CODE_W-1:0] staged [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                staged[i] <= CODE_W'(RESET_CODE);
            end else if (we && (addr == ADDR_W'(i))) begin
                staged[i] <= wdata;
            end
        end

        assign staged_flat[i*CODE_W +: CODE_W] = staged[i];

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == ADDR_W'(i)) |=> (staged[i] == $past(wdata))); // R1
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) rdata = staged[i];
        end
    end

endmodule

// File: rtl/pwm_period_seq.sv
module pwm_period_seq
    import pwm_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int SHORT_TRIM = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_period,
    output logic [CODE_W-1:0] cnt,
    output logic              load
);

    localparam logic [CODE_W-1:0] LONG_LAST  = CODE_W'(period_last(CODE_W, 0));
    localparam logic [CODE_W-1:0] SHORT_LAST = CODE_W'(period_last(CODE_W, SHORT_TRIM));

    seq_state_t        state_q, state_d;
    logic              mode_q;
    logic              mode_chg;
    logic [CODE_W-1:0] last;
    logic [CODE_W-1:0] cnt_inc;
    logic [CODE_W-1:0] cnt_d;

    assign mode_chg = short_period != mode_q;
    assign last     = mode_q ? SHORT_LAST : LONG_LAST;
    assign cnt_inc  = cnt + CODE_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_COUNT;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= short_period;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (mode_chg) begin
            state_d = SEQ_COUNT;
        end else begin
            unique case (state_q)
                SEQ_COUNT: state_d = (cnt_inc == last) ? SEQ_LAST : SEQ_COUNT;
                SEQ_LAST:  state_d = SEQ_COUNT;
                default:   state_d = SEQ_COUNT;
            endcase
        end
    end

    // outputs: counter and reload strobe
    always_comb begin
        cnt_d = cnt;
        load  = mode_chg;
        if (mode_chg) begin
            cnt_d = '0;
        end else begin
            unique case (state_q)
                SEQ_COUNT: cnt_d = cnt_inc;
                SEQ_LAST: begin
                    cnt_d = '0;
                    load  = 1'b1;
                end
                default:   cnt_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last); // R2
    AST_LAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LAST) |-> (cnt == last)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LAST && !mode_chg) |=> (cnt == '0)); // R2
    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (cnt == '0 && state_q == SEQ_COUNT)); // R9

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CODE_W     = 8,
    parameter int RESET_CODE = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] cnt,
    input  logic [CODE_W-1:0] staged,
    output logic              pull_low
);

    logic [CODE_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= CODE_W'(RESET_CODE);
            pull_low <= 1'b0;
        end else begin
            if (load) shadow_q <= staged;
            pull_low <= !(cnt < shadow_q);
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow_q)); // R7
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q == '0) |=> pull_low); // R5
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && shadow_q != '0) |=> !pull_low); // R3

endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank #(
    parameter int NUM_CH     = 14,
    parameter int CODE_W     = 8,
    parameter int ADDR_W     = $clog2(NUM_CH),
    parameter int SHORT_TRIM = 3,
    parameter int RESET_CODE = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_period,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CODE_W-1:0] reg_wdata,
    output logic [CODE_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] dac_pull_low
);

    localparam int FLAT_W = NUM_CH * CODE_W;

    logic [FLAT_W-1:0] staged_flat;
    logic [CODE_W-1:0] cnt;
    logic              load;

    pwm_code_regs #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .RESET_CODE(RESET_CODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .staged_flat(staged_flat)
    );

    pwm_period_seq #(
        .CODE_W(CODE_W), .SHORT_TRIM(SHORT_TRIM)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .short_period(short_period),
        .cnt(cnt), .load(load)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel #(
            .CODE_W(CODE_W), .RESET_CODE(RESET_CODE)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .load(load), .cnt(cnt),
            .staged(staged_flat[i*CODE_W +: CODE_W]),
            .pull_low(dac_pull_low[i])
        );
    end

endmodule

// File: tb/pwm_dac_bank_bench.sv
module pwm_dac_bank_bench;

    localparam int NCH = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        short_period = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [13:0] dac_pull_low;

    int n_checks = 0;
    int n_fail   = 0;
    int hi [NCH];
    longint cycles = 0;

    always #5 clk = ~clk;

    pwm_dac_bank u_pwm_dac_bank (
        .clk(clk), .rst_n(rst_n), .short_period(short_period),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dac_pull_low(dac_pull_low)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(ch); reg_wdata = 8'(val);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic settle(input int p);
        repeat (2 * p + 4) @(negedge clk);
    endtask

    task automatic measure(input int p);
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        repeat (p) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) hi[c] += int'(!dac_pull_low[c]);
        end
    endtask

    task automatic wait_rise(input int ch);
        bit prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (prev == 1'b0 && !dac_pull_low[ch]) break;
            prev = !dac_pull_low[ch];
        end
    endtask

    task automatic t_reset();
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk);
            reg_addr = 4'(c);
            #1;
            check(reg_rdata == 8'h80, "R8 reset code", reg_rdata, 8'h80);
        end
        settle(256);
        measure(256);
        for (int c = 0; c < NCH; c++) check(hi[c] == 128, "R8 reset duty", hi[c], 128);
    endtask

    task automatic t_readback();
        for (int c = 0; c < NCH; c++) wr(c, c * 17 + 3);
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk);
            reg_addr = 4'(c);
            #1;
            check(reg_rdata == 8'(c * 17 + 3), "R1 readback", reg_rdata, c * 17 + 3);
        end
    endtask

    task automatic t_duty256();
        settle(256);
        measure(256);
        for (int c = 0; c < NCH; c++)
            check(hi[c] == c * 17 + 3, "R3 R10 duty per channel", hi[c], c * 17 + 3);
    endtask

    task automatic t_ends256();
        wr(0, 8'h00); wr(1, 8'hFF); wr(2, 8'h01); wr(3, 8'hFE);
        settle(256);
        measure(512);
        check(hi[0] == 0,   "R5 zero code 256 mode", hi[0], 0);
        check(hi[1] == 510, "R6 FFh in 256 mode",    hi[1], 510);
        check(hi[2] == 2,   "R3 code 01h",           hi[2], 2);
        check(hi[3] == 508, "R3 code FEh",           hi[3], 508);
    endtask

    task automatic t_period(input int p, input string req);
        int len;
        wr(8, 8'h80);
        settle(p);
        wait_rise(8);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!(dac_pull_low[8] == 1'b0 && len > 200));
        check(len == p, req, len, p);
    endtask

    task automatic t_sat253();
        @(negedge clk); short_period = 1'b1;
        wr(0, 8'h00); wr(2, 8'hFD); wr(3, 8'hFE); wr(4, 8'hFF);
        wr(5, 8'hFC); wr(9, 8'h80);
        settle(253);
        measure(506);
        check(hi[0] == 0,   "R5 zero code 253 mode", hi[0], 0);
        check(hi[2] == 506, "R4 FDh constant high",  hi[2], 506);
        check(hi[3] == 506, "R4 FEh constant high",  hi[3], 506);
        check(hi[4] == 506, "R4 FFh constant high",  hi[4], 506);
        check(hi[5] == 504, "R3 FCh in 253 mode",    hi[5], 504);
        check(hi[9] == 256, "R3 80h in 253 mode",    hi[9], 256);
        t_period(253, "R2 period 253");
        @(negedge clk); short_period = 1'b0;
    endtask

    task automatic t_deferred();
        int h1;
        int h2;
        wr(6, 8'h40);
        settle(256);
        wait_rise(6);
        h1 = 1;
        for (int k = 1; k < 256; k++) begin
            @(negedge clk);
            h1 += int'(!dac_pull_low[6]);
            if (k == 4) begin reg_we = 1'b1; reg_addr = 4'd6; reg_wdata = 8'hC0; end
            if (k == 5) reg_we = 1'b0;
        end
        h2 = 0;
        repeat (256) begin
            @(negedge clk);
            h2 += int'(!dac_pull_low[6]);
        end
        check(h1 == 8'h40, "R7 old code holds current period", h1, 8'h40);
        check(h2 == 8'hC0, "R7 new code next period",         h2, 8'hC0);
    endtask

    task automatic t_restart();
        int h;
        wr(7, 8'h10);
        settle(256);
        wait_rise(7);
        repeat (40) @(negedge clk);
        check(dac_pull_low[7] == 1'b1, "R9 low before change", dac_pull_low[7], 1);
        short_period = 1'b1;
        @(negedge clk);
        check(dac_pull_low[7] == 1'b1, "R9 still low one clock after", dac_pull_low[7], 1);
        @(negedge clk);
        check(dac_pull_low[7] == 1'b0, "R9 released two clocks after", dac_pull_low[7], 0);
        h = 1;
        repeat (252) begin
            @(negedge clk);
            h += int'(!dac_pull_low[7]);
        end
        check(h == 16, "R9 restarted period duty", h, 16);
        @(negedge clk); short_period = 1'b0;
        settle(256);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_duty256();
        t_ends256();
        t_period(256, "R2 period 256");
        t_sat253();
        t_deferred();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule